// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds eight 16-bit general-purpose registers. Each access carries a 3-bit index and a width flag. With the flag clear the index picks a whole register. With the flag set, the same index picks one byte. Byte indices 0 to 3 pick the low byte of registers 0 to 3. Byte indices 4 to 7 pick the high byte of registers 0 to 3. So in byte mode, registers 4 to 7 cannot be reached at all.

There are two combinational read ports and one write port. The write port is clocked and has its own width flag. A byte write changes only the addressed byte. A byte read returns the addressed byte in the low eight bits of the read port, with zeros above it. The intended user is an instruction datapath. Its operand fields pick registers directly, so the word map is 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI. The byte map is 0=AL, 1=CL, 2=DL, 3=BL, 4=AH, 5=CH, 6=DH, 7=BH.

Top module: `gpr_alias_file`

## Requirements
- R1: When `rst` is high at a rising clock edge, all eight registers become zero. Every read after that edge returns 0x0000 until the next write.
- R2: A word write (`wr_en`=1, `wr_byte`=0) replaces all 16 bits of register `wr_idx` at the clock edge.
- R3: A byte write to index 0 to 3 replaces bits 7:0 of the register with that index, using `wr_data[7:0]`. Bits 15:8 of that register keep their value.
- R4: A byte write to index k in 4 to 7 replaces bits 15:8 of register k-4, using `wr_data[7:0]`. Bits 7:0 of register k-4 keep their value, and registers 4 to 7 are unchanged.
- R5: A byte read of index 0 to 3 returns bits 7:0 of the register with that index on bits 7:0 of the port, with bits 15:8 of the port zero.
- R6: A byte read of index k in 4 to 7 returns bits 15:8 of register k-4 on bits 7:0 of the port, with bits 15:8 of the port zero.
- R7: Reads are combinational. A read of a register in the same cycle it is written returns the old value, and the new value appears after the edge.
- R8: The two read ports each have their own index and width flag and work independently of each other.
- R9: With `wr_en` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | Write width: 1 = byte, 0 = word |
| wr_idx | input | 3 | Write index |
| wr_data | input | 16 | Write data; only bits 7:0 are used for byte writes |
| rd0_byte | input | 1 | Read port 0 width: 1 = byte, 0 = word |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_data | output | 16 | Read port 0 data |
| rd1_byte | input | 1 | Read port 1 width: 1 = byte, 0 = word |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_data | output | 16 | Read port 1 data |

## Verification
The clocked properties assume every control input has a known 0 or 1 value at each sampled edge. The write properties also assume `wr_idx` and `wr_data` are known whenever `wr_en` is high, because the expected register contents are taken from those inputs one cycle earlier. The bench drives every input on the falling edge from the first cycle on, holds `rst` high from time zero, and never leaves a field undriven. As a result, each antecedent sees defined values and no property is evaluated on an unknown write target.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
    localparam int GPR_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int GPR_N   = 8;
    localparam int IDX_W   = $clog2(GPR_N);
    localparam int LANES   = GPR_W / BYTE_W;
    localparam int ALIAS_N = GPR_N / LANES;

    typedef logic [GPR_W-1:0]            gpr_word_t;
    typedef gpr_word_t [GPR_N-1:0]       gpr_bank_t;
    typedef logic [GPR_N-1:0][LANES-1:0] gpr_lane_we_t;

    typedef struct packed {
        gpr_bank_t regs;
    } gpr_state_t;
endpackage

// File: rtl/gpr_write_decode.sv
`timescale 1ns/1ps
module gpr_write_decode #(
    parameter int N     = gpr_pkg::GPR_N,
    parameter int W     = gpr_pkg::GPR_W,
    parameter int BW    = gpr_pkg::BYTE_W,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                     wr_en,
    input  logic                     wr_byte,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [W-1:0]             wr_data,
    output logic [N-1:0][W/BW-1:0]   lane_we,
    output logic [W-1:0]             lane_wdata
);
    localparam int LANES = W / BW;
    localparam int ALIAS = N / LANES;

    int reg_sel;
    int lane_sel;

    always_comb begin
        reg_sel  = int'(wr_idx) % ALIAS;
        lane_sel = int'(wr_idx) / ALIAS;
        lane_we  = '0;
        if (wr_en) begin
            if (!wr_byte) begin
                lane_we[wr_idx] = '1;
            end else begin
                lane_we[reg_sel][lane_sel] = 1'b1;
            end
        end
    end

    // In byte mode the low byte of the input is copied to every lane.
    always_comb begin
        if (wr_byte) begin
            lane_wdata = {LANES{wr_data[BW-1:0]}};
        end else begin
            lane_wdata = wr_data;
        end
    end
endmodule

// File: rtl/gpr_read_port.sv
`timescale 1ns/1ps
module gpr_read_port #(
    parameter int N     = gpr_pkg::GPR_N,
    parameter int W     = gpr_pkg::GPR_W,
    parameter int BW    = gpr_pkg::BYTE_W,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] bank,
    input  logic                byte_sel,
    input  logic [IDX_W-1:0]    idx,
    output logic [W-1:0]        data
);
    localparam int LANES = W / BW;
    localparam int ALIAS = N / LANES;

    int reg_sel;
    int lane_sel;

    always_comb begin
        reg_sel  = int'(idx) % ALIAS;
        lane_sel = int'(idx) / ALIAS;
        data     = '0;
        if (byte_sel) begin
            data[BW-1:0] = bank[reg_sel][lane_sel*BW +: BW];
        end else begin
            data = bank[idx];
        end
    end
endmodule

// File: rtl/gpr_alias_file.sv
`timescale 1ns/1ps
module gpr_alias_file
    import gpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_byte,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [GPR_W-1:0] wr_data,
    input  logic             rd0_byte,
    input  logic [IDX_W-1:0] rd0_idx,
    output logic [GPR_W-1:0] rd0_data,
    input  logic             rd1_byte,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic [GPR_W-1:0] rd1_data
);
    gpr_state_t   state_d, state_q;
    gpr_lane_we_t lane_we;
    gpr_word_t    lane_wdata;

    gpr_write_decode #(.N(GPR_N), .W(GPR_W), .BW(BYTE_W), .IDX_W(IDX_W)) u_wdec (
        .wr_en      (wr_en),
        .wr_byte    (wr_byte),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.regs = '0;
        end else begin
            for (int r = 0; r < GPR_N; r++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_we[r][l]) begin
                        state_d.regs[r][l*BYTE_W +: BYTE_W] = lane_wdata[l*BYTE_W +: BYTE_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    gpr_read_port #(.N(GPR_N), .W(GPR_W), .BW(BYTE_W), .IDX_W(IDX_W)) u_rd0 (
        .bank     (state_q.regs),
        .byte_sel (rd0_byte),
        .idx      (rd0_idx),
        .data     (rd0_data)
    );

    gpr_read_port #(.N(GPR_N), .W(GPR_W), .BW(BYTE_W), .IDX_W(IDX_W)) u_rd1 (
        .bank     (state_q.regs),
        .byte_sel (rd1_byte),
        .idx      (rd1_idx),
        .data     (rd1_data)
    );

    // Checks on the storage and the read paths
    AST_WORD_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_byte) |=> (state_q.regs[$past(wr_idx)] == $past(wr_data))); // R2

    AST_LOW_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte && !wr_idx[IDX_W-1]) |=>
        ((state_q.regs[$past(wr_idx[IDX_W-2:0])][BYTE_W-1:0] == $past(wr_data[BYTE_W-1:0])) &&
         (state_q.regs[$past(wr_idx[IDX_W-2:0])][GPR_W-1:BYTE_W] ==
          $past(state_q.regs[wr_idx[IDX_W-2:0]][GPR_W-1:BYTE_W])))); // R3

    AST_HIGH_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte && wr_idx[IDX_W-1]) |=>
        ((state_q.regs[$past(wr_idx[IDX_W-2:0])][GPR_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0])) &&
         (state_q.regs[$past(wr_idx[IDX_W-2:0])][BYTE_W-1:0] ==
          $past(state_q.regs[wr_idx[IDX_W-2:0]][BYTE_W-1:0])))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(state_q.regs)); // R9

    AST_RD0_LOW_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (rd0_byte && !rd0_idx[IDX_W-1]) |->
        (rd0_data == {{(GPR_W-BYTE_W){1'b0}}, state_q.regs[rd0_idx[IDX_W-2:0]][BYTE_W-1:0]})); // R5

    AST_RD1_HIGH_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (rd1_byte && rd1_idx[IDX_W-1]) |->
        (rd1_data == {{(GPR_W-BYTE_W){1'b0}}, state_q.regs[rd1_idx[IDX_W-2:0]][GPR_W-1:BYTE_W]})); // R6
endmodule

// File: tb/tb_gpr_alias_file.sv
`timescale 1ns/1ps
module tb_gpr_alias_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_byte = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        rd0_byte = 1'b0, rd1_byte = 1'b0;
    logic [2:0]  rd0_idx = '0, rd1_idx = '0;
    logic [15:0] rd0_data, rd1_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] model [8];

    always #2.5 clk = ~clk;

    gpr_alias_file dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd0_byte(rd0_byte), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_byte(rd1_byte), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
    );

    typedef struct packed {
        logic        we;
        logic        wb;
        logic [2:0]  wi;
        logic [15:0] wd;
        logic        b0;
        logic [2:0]  i0;
        logic        b1;
        logic [2:0]  i1;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{1'b1, 1'b0, 3'd0, 16'h1A2B, 1'b0, 3'd0, 1'b0, 3'd1},
        '{1'b1, 1'b0, 3'd1, 16'h3C4D, 1'b0, 3'd0, 1'b1, 3'd0},
        '{1'b1, 1'b0, 3'd2, 16'h5E6F, 1'b1, 3'd4, 1'b0, 3'd1},
        '{1'b1, 1'b0, 3'd3, 16'h7081, 1'b1, 3'd1, 1'b1, 3'd5},
        '{1'b1, 1'b0, 3'd4, 16'h92A3, 1'b1, 3'd6, 1'b0, 3'd3},
        '{1'b1, 1'b0, 3'd5, 16'hB4C5, 1'b1, 3'd7, 1'b1, 3'd3},
        '{1'b1, 1'b0, 3'd6, 16'hD6E7, 1'b0, 3'd4, 1'b0, 3'd5},
        '{1'b1, 1'b0, 3'd7, 16'hF809, 1'b0, 3'd6, 1'b1, 3'd2},
        '{1'b1, 1'b1, 3'd0, 16'hFF11, 1'b0, 3'd7, 1'b0, 3'd0},
        '{1'b1, 1'b1, 3'd4, 16'hEE22, 1'b0, 3'd0, 1'b1, 3'd4},
        '{1'b1, 1'b1, 3'd3, 16'hDD33, 1'b1, 3'd0, 1'b0, 3'd4},
        '{1'b1, 1'b1, 3'd7, 16'hCC44, 1'b1, 3'd3, 1'b1, 3'd7},
        '{1'b0, 1'b0, 3'd2, 16'hBBBB, 1'b0, 3'd3, 1'b0, 3'd7},
        '{1'b1, 1'b1, 3'd6, 16'hAA55, 1'b0, 3'd2, 1'b1, 3'd6},
        '{1'b1, 1'b1, 3'd1, 16'h0066, 1'b0, 3'd1, 1'b1, 3'd2},
        '{1'b0, 1'b1, 3'd5, 16'h9977, 1'b0, 3'd6, 1'b0, 3'd4}
    };

    function automatic logic [15:0] model_read(logic b, logic [2:0] i);
        if (!b) return model[i];
        if (i < 4) return {8'h00, model[i][7:0]};
        return {8'h00, model[i-4][15:8]};
    endfunction

    function automatic string auto_tag(logic b, logic [2:0] i);
        if (!b) return "R2";
        if (i < 4) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, compare reads before the rising edge,
    // then apply the write to the model.
    task automatic step(logic r, logic we, logic wb, logic [2:0] wi, logic [15:0] wd,
                        logic b0, logic [2:0] i0, logic b1, logic [2:0] i1, string tag);
        @(negedge clk);
        rst = r; wr_en = we; wr_byte = wb; wr_idx = wi; wr_data = wd;
        rd0_byte = b0; rd0_idx = i0; rd1_byte = b1; rd1_idx = i1;
        #1;
        check((tag == "") ? auto_tag(b0, i0) : tag, rd0_data, model_read(b0, i0));
        check((tag == "") ? auto_tag(b1, i1) : tag, rd1_data, model_read(b1, i1));
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < 8; k++) model[k] = 16'h0000;
        end else if (we) begin
            if (!wb) model[wi] = wd;
            else if (wi < 4) model[wi][7:0] = wd[7:0];
            else model[wi-4][15:8] = wd[7:0];
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = 16'hxxxx;
        step(1'b1, 1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 1'b0, 3'd0, "R1-setup");
        n_checks = 0; n_fails = 0;
        // R1: reset state on every word and byte view
        for (int k = 0; k < 8; k++)
            step(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 3'(k), 1'b1, 3'(k), "R1");

        // Table walk; R8: two ports with differing index and width
        foreach (VECS[v])
            step(1'b0, VECS[v].we, VECS[v].wb, VECS[v].wi, VECS[v].wd,
                 VECS[v].b0, VECS[v].i0, VECS[v].b1, VECS[v].i1, "");
        step(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 3'd5, 1'b0, 3'd1, "R8");

        // R7: read of the register being written returns old value, then new
        step(1'b0, 1'b1, 1'b0, 3'd2, 16'h1234, 1'b0, 3'd2, 1'b1, 3'd2, "R7");
        step(1'b0, 1'b1, 1'b1, 3'd6, 16'h00AB, 1'b0, 3'd2, 1'b1, 3'd6, "R7");
        step(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 3'd2, 1'b1, 3'd6, "R7");

        // R3: low byte write keeps the high byte
        step(1'b0, 1'b1, 1'b0, 3'd1, 16'hA5C3, 1'b0, 3'd0, 1'b0, 3'd0, "R3");
        step(1'b0, 1'b1, 1'b1, 3'd1, 16'hFF77, 1'b0, 3'd1, 1'b0, 3'd1, "R3");
        step(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 3'd1, 1'b1, 3'd5, "R3");

        // R4: high byte write aliases register k-4 and leaves register k alone
        step(1'b0, 1'b1, 1'b0, 3'd5, 16'h5555, 1'b0, 3'd5, 1'b0, 3'd1, "R4");
        step(1'b0, 1'b1, 1'b1, 3'd5, 16'h339E, 1'b0, 3'd5, 1'b0, 3'd1, "R4");
        step(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 3'd5, 1'b0, 3'd1, "R4");
        check("R4", rd0_data, 16'h5555);

        // R9: disabled write with active-looking inputs changes nothing
        step(1'b0, 1'b0, 1'b0, 3'd1, 16'hDEAD, 1'b0, 3'd1, 1'b0, 3'd1, "R9");
        step(1'b0, 1'b0, 1'b1, 3'd5, 16'hBEEF, 1'b0, 3'd1, 1'b0, 3'd5, "R9");
        step(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 3'd1, 1'b0, 3'd5, "R9");

        // R1: reset in the middle of a run
        step(1'b1, 1'b1, 1'b0, 3'd3, 16'hFFFF, 1'b0, 3'd3, 1'b0, 3'd1, "R1");
        for (int k = 0; k < 8; k++)
            step(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, 1'b0, 3'(k), 1'b1, 3'(7-k), "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule